// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps a precision-time-protocol clock as a seconds count and a nanoseconds count. Every cycle of the reference clock it adds a 64-bit unsigned fixed-point increment: the upper 32 bits are whole nanoseconds and the lower 32 bits are a binary fraction of a nanosecond. The fraction is kept from cycle to cycle, so any reference frequency can be followed. For a reference of F Hz the nominal increment is (10^9 · 2^32) / F. Software trims the frequency at runtime by writing a new increment.

When the nanoseconds count reaches one billion it does not drop to zero. It keeps the part above one billion, and the seconds count steps by one in the same cycle. Over many seconds this loses no time. A pulse-per-second output runs on the same increment. Its high and low durations are each a 32.32 nanosecond value, and the part of the last step that went past a duration is carried into the next phase. A rising edge on the event input takes a copy of the time. Software reads the copy through the register port, and that read clears its valid flag.

Software loads the time by staging the seconds and then writing the nanoseconds. That second write loads both counts in one cycle, clears the fraction and starts the pulse output over in its high phase. The event input must be synchronous to `clk`. The whole-nanosecond part of the increment must stay below one billion. Each pulse duration must be at least one increment.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the seconds and nanoseconds are 0, counting is disabled (control register 0), the pulse output is high, the capture flag is clear, and the increment reads back its reset value (10.0 ns by default).
- R2: In each cycle where counting is enabled, the 32.32 increment is added to the time. A carry out of the 32-bit fraction adds one nanosecond in the same cycle as the whole-nanosecond part.
- R3: A sum of 1,000,000,000 ns (0x3B9ACA00) or more is reduced by exactly 1,000,000,000 and the seconds step by one in that same cycle. 999,999,999 (0x3B9AC9FF) is a legal value and does not wrap. The fraction is kept across the wrap.
- R4: While control bit 0 is 0, or while the increment is zero, the seconds and nanoseconds hold their values.
- R5: A write to address 4 loads the nanoseconds from the written data and the seconds from the value staged at address 3. The load is visible after the next clock edge, takes the place of that cycle's increment, and clears the fraction.
- R6: An increment written at address 1 (fraction) or address 2 (whole ns) is used from the cycle after the write. The cycle of the write itself uses the previous increment.
- R7: The pulse output toggles in each cycle where the phase accumulated since its last edge, plus the increment, reaches the current duration. That duration is high (addresses 6 whole / 5 fraction) while the output is high, and low (8 / 7) while it is low. The excess is carried into the next phase. A time load restarts the output high with zero phase. Both durations default to 500,000,000 ns.
- R8: A rising edge on `evt_in` copies the time present at that clock edge to capture registers (seconds at address 11, ns at address 12) and sets the valid flag, read at address 13 bit 0. A read of address 13 with `rd_en` high clears the flag, unless a new capture happens in the same cycle. A level held high captures only once.
- R9: The read port is combinational:
  - addresses 0–3 and 5–8 return the stored register values;
  - address 4 returns 0;
  - address 9 returns the live seconds and address 10 the live nanoseconds;
  - addresses 14–15 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Read strobe; used to clear the capture flag |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data for `rd_addr` (combinational) |
| evt_in | input | 1 | Event input, synchronous to `clk` |
| pps_out | output | 1 | Pulse-per-second output |
| tod_sec | output | SEC_W | Live seconds |
| tod_ns | output | 32 | Live nanoseconds |

## Verification
Time, the pulse output and the capture registers change at the first clock edge after their cause. Register writes, loads, enables and increments driven before an edge take effect on the outputs seen after that edge, and the reference model applies each stimulus at the same edge. The bench drives inputs and compares outputs at falling edges, half a cycle away from the updates. Reads are combinational, so each read is sampled 1 ns after its address is set. Directed checks at the 999,999,999 boundary, at a fractional wrap and at each pulse phase sit at the exact cycle counts worked out from R2, R3 and R7.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam logic [31:0] NS_PER_SEC = 32'd1_000_000_000;
  localparam int AW = 4;

  localparam logic [AW-1:0] A_CTRL     = 4'd0;
  localparam logic [AW-1:0] A_INC_FRAC = 4'd1;
  localparam logic [AW-1:0] A_INC_INT  = 4'd2;
  localparam logic [AW-1:0] A_LD_SEC   = 4'd3;
  localparam logic [AW-1:0] A_LD_NS    = 4'd4;
  localparam logic [AW-1:0] A_HI_FRAC  = 4'd5;
  localparam logic [AW-1:0] A_HI_INT   = 4'd6;
  localparam logic [AW-1:0] A_LO_FRAC  = 4'd7;
  localparam logic [AW-1:0] A_LO_INT   = 4'd8;
  localparam logic [AW-1:0] A_NOW_SEC  = 4'd9;
  localparam logic [AW-1:0] A_NOW_NS   = 4'd10;
  localparam logic [AW-1:0] A_CAP_SEC  = 4'd11;
  localparam logic [AW-1:0] A_CAP_NS   = 4'd12;
  localparam logic [AW-1:0] A_CAP_STAT = 4'd13;

  typedef struct packed {
    logic [31:0] ns;
    logic [31:0] frac;
    logic        roll;
  } ns_step_t;

  typedef struct packed {
    logic [63:0] phase;
    logic        hit;
  } pps_step_t;

  // One increment step of the nanosecond counter, with a single wrap.
  function automatic ns_step_t ns_advance(logic [31:0] ns, logic [31:0] frac,
                                          logic [63:0] inc);
    ns_step_t    r;
    logic [32:0] fsum;
    logic [33:0] nsum;
    fsum   = {1'b0, frac} + {1'b0, inc[31:0]};
    nsum   = {2'b00, ns} + {2'b00, inc[63:32]} + {33'd0, fsum[32]};
    r.roll = (nsum >= {2'b00, NS_PER_SEC});
    r.ns   = r.roll ? 32'(nsum - {2'b00, NS_PER_SEC}) : nsum[31:0];
    r.frac = fsum[31:0];
    return r;
  endfunction

  // One step of the pulse phase towards a 32.32 duration.
  function automatic pps_step_t pps_advance(logic [63:0] phase, logic [63:0] inc,
                                            logic [63:0] dur);
    pps_step_t   r;
    logic [64:0] sum;
    sum     = {1'b0, phase} + {1'b0, inc};
    r.hit   = (sum >= {1'b0, dur});
    r.phase = r.hit ? 64'(sum - {1'b0, dur}) : sum[63:0];
    return r;
  endfunction
endpackage

// File: rtl/tod_ns_accum.sv
module tod_ns_accum
  import tod_pkg::*;
#(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [63:0]      inc,
  input  logic             load,
  input  logic [SEC_W-1:0] load_sec,
  input  logic [31:0]      load_ns,
  output logic [SEC_W-1:0] sec,
  output logic [31:0]      ns
);
  logic [SEC_W-1:0] sec_q;
  logic [31:0]      ns_q;
  logic [31:0]      frac_q;
  ns_step_t         nxt;
  logic             roll;

  always_comb nxt = ns_advance(ns_q, frac_q, inc);
  assign roll = en && nxt.roll;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      ns_q   <= '0;
      frac_q <= '0;
    end else if (load) begin
      sec_q  <= load_sec;
      ns_q   <= load_ns;
      frac_q <= '0;
    end else if (en) begin
      ns_q   <= nxt.ns;
      frac_q <= nxt.frac;
      if (nxt.roll) sec_q <= sec_q + 1'b1;
    end
  end

  assign sec = sec_q;
  assign ns  = ns_q;

  // R3: a step from a legal value stays below one billion
  a_r3_ns_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && ns_q < NS_PER_SEC) |=> ns_q < NS_PER_SEC);
  // R3: a wrap adds exactly one second
  a_r3_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (roll && !load) |=> sec_q == $past(sec_q) + 1'b1);
  // R4: disabled counter holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> ($stable(ns_q) && $stable(sec_q) && $stable(frac_q)));
  // R5: load takes the written value and clears the fraction
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ns_q == $past(load_ns) && frac_q == 32'd0));
endmodule

// File: rtl/tod_pps_gen.sv
module tod_pps_gen
  import tod_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [63:0] inc,
  input  logic [63:0] dur_hi,
  input  logic [63:0] dur_lo,
  input  logic        realign,
  output logic        pps
);
  logic [63:0] phase_q;
  logic        lvl_q;
  pps_step_t   nxt;
  logic        hit;

  always_comb nxt = pps_advance(phase_q, inc, lvl_q ? dur_hi : dur_lo);
  assign hit = en && nxt.hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      lvl_q   <= 1'b1;
    end else if (realign) begin
      phase_q <= '0;
      lvl_q   <= 1'b1;
    end else if (en) begin
      phase_q <= nxt.phase;
      if (nxt.hit) lvl_q <= ~lvl_q;
    end
  end

  assign pps = lvl_q;

  // R7: level changes only on a duration hit
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !realign) |=> $stable(lvl_q));
  a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !realign) |=> lvl_q != $past(lvl_q));
  a_r7_realign: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (lvl_q && phase_q == 64'd0));
endmodule

// File: rtl/tod_evt_capture.sv
module tod_evt_capture #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [SEC_W-1:0] sec,
  input  logic [31:0]      ns,
  input  logic             clr,
  output logic [SEC_W-1:0] cap_sec,
  output logic [31:0]      cap_ns,
  output logic             valid
);
  logic evt_q;
  logic fire;

  assign fire = evt && !evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q   <= 1'b0;
      cap_sec <= '0;
      cap_ns  <= '0;
      valid   <= 1'b0;
    end else begin
      evt_q <= evt;
      if (fire) begin
        cap_sec <= sec;
        cap_ns  <= ns;
        valid   <= 1'b1;
      end else if (clr) begin
        valid <= 1'b0;
      end
    end
  end

  // R8: capture sets the flag and holds the time of the edge
  a_r8_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (valid && cap_ns == $past(ns)));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fire) |=> !valid);
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import tod_pkg::*;
#(
  parameter int          SEC_W     = 32,
  parameter logic [63:0] INC_RESET = 64'h0000_000A_0000_0000,
  parameter logic [63:0] HI_RESET  = 64'h1DCD_6500_0000_0000,
  parameter logic [63:0] LO_RESET  = 64'h1DCD_6500_0000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  input  logic [3:0]       rd_addr,
  output logic [31:0]      rd_data,
  input  logic             evt_in,
  output logic             pps_out,
  output logic [SEC_W-1:0] tod_sec,
  output logic [31:0]      tod_ns
);
  logic [31:0]      ctrl_q;
  logic [63:0]      inc_q;
  logic [31:0]      stage_q;
  logic [63:0]      hi_q;
  logic [63:0]      lo_q;
  logic             load;
  logic             cap_clr;
  logic [SEC_W-1:0] cap_sec;
  logic [31:0]      cap_ns;
  logic             cap_valid;

  assign load    = wr_en && (wr_addr == A_LD_NS);
  assign cap_clr = rd_en && (rd_addr == A_CAP_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      inc_q   <= INC_RESET;
      stage_q <= '0;
      hi_q    <= HI_RESET;
      lo_q    <= LO_RESET;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:     ctrl_q         <= wr_data;
        A_INC_FRAC: inc_q[31:0]    <= wr_data;
        A_INC_INT:  inc_q[63:32]   <= wr_data;
        A_LD_SEC:   stage_q        <= wr_data;
        A_HI_FRAC:  hi_q[31:0]     <= wr_data;
        A_HI_INT:   hi_q[63:32]    <= wr_data;
        A_LO_FRAC:  lo_q[31:0]     <= wr_data;
        A_LO_INT:   lo_q[63:32]    <= wr_data;
        default: ;
      endcase
    end
  end

  tod_ns_accum #(.SEC_W(SEC_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctrl_q[0]),
    .inc      (inc_q),
    .load     (load),
    .load_sec (SEC_W'(stage_q)),
    .load_ns  (wr_data),
    .sec      (tod_sec),
    .ns       (tod_ns)
  );

  tod_pps_gen u_pps (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl_q[0]),
    .inc     (inc_q),
    .dur_hi  (hi_q),
    .dur_lo  (lo_q),
    .realign (load),
    .pps     (pps_out)
  );

  tod_evt_capture #(.SEC_W(SEC_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt_in),
    .sec     (tod_sec),
    .ns      (tod_ns),
    .clr     (cap_clr),
    .cap_sec (cap_sec),
    .cap_ns  (cap_ns),
    .valid   (cap_valid)
  );

  // R9: read map
  always_comb begin
    case (rd_addr)
      A_CTRL:     rd_data = ctrl_q;
      A_INC_FRAC: rd_data = inc_q[31:0];
      A_INC_INT:  rd_data = inc_q[63:32];
      A_LD_SEC:   rd_data = stage_q;
      A_HI_FRAC:  rd_data = hi_q[31:0];
      A_HI_INT:   rd_data = hi_q[63:32];
      A_LO_FRAC:  rd_data = lo_q[31:0];
      A_LO_INT:   rd_data = lo_q[63:32];
      A_NOW_SEC:  rd_data = 32'(tod_sec);
      A_NOW_NS:   rd_data = tod_ns;
      A_CAP_SEC:  rd_data = 32'(cap_sec);
      A_CAP_NS:   rd_data = cap_ns;
      A_CAP_STAT: rd_data = {31'd0, cap_valid};
      default:    rd_data = 32'd0;
    endcase
  end

  // R6: a written increment is held until the next write to it
  a_r6_inc_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == A_INC_FRAC || wr_addr == A_INC_INT)) |=> $stable(inc_q));
endmodule

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        evt_in = 1'b0;
  logic        pps_out;
  logic [31:0] tod_sec;
  logic [31:0] tod_ns;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ptp_time_counter u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_in(evt_in), .pps_out(pps_out), .tod_sec(tod_sec), .tod_ns(tod_ns)
  );

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  localparam longint unsigned BQ = 64'd1_000_000_000 << 32;
  longint unsigned m_sec = 0, m_ns = 0, m_frac = 0;
  longint unsigned m_inc = 64'hA_0000_0000;
  longint unsigned m_hi = 64'h1DCD6500_00000000, m_lo = 64'h1DCD6500_00000000;
  longint unsigned m_ph = 0, m_stage = 0;
  bit m_en = 0, m_lvl = 1, m_prev = 0, m_valid = 0;
  longint unsigned m_cap_sec = 0, m_cap_ns = 0;

  always @(posedge clk) begin
    longint unsigned t, tgt;
    if (!rst_n) begin
      m_sec = 0; m_ns = 0; m_frac = 0; m_inc = 64'hA_0000_0000;
      m_hi = 64'h1DCD6500_00000000; m_lo = m_hi; m_ph = 0; m_stage = 0;
      m_en = 0; m_lvl = 1; m_prev = 0; m_valid = 0;
    end else begin
      if (evt_in && !m_prev) begin
        m_cap_sec = m_sec; m_cap_ns = m_ns; m_valid = 1;
      end else if (rd_en && rd_addr == 4'd13) m_valid = 0;
      m_prev = evt_in;
      if (wr_en && wr_addr == 4'd4) begin
        m_sec = m_stage; m_ns = wr_data; m_frac = 0; m_ph = 0; m_lvl = 1;
      end else if (m_en) begin
        t = (m_ns << 32) + m_frac + m_inc;
        if (t >= BQ) begin t -= BQ; m_sec++; end
        m_ns = t >> 32; m_frac = t & 64'hFFFF_FFFF;
        m_ph += m_inc;
        tgt = m_lvl ? m_hi : m_lo;
        if (m_ph >= tgt) begin m_ph -= tgt; m_lvl = !m_lvl; end
      end
      if (wr_en) case (wr_addr)
        4'd0: m_en = wr_data[0];
        4'd1: m_inc = (m_inc & 64'hFFFFFFFF_00000000) | wr_data;
        4'd2: m_inc = (m_inc & 64'h00000000_FFFFFFFF) | (longint'(wr_data) << 32);
        4'd3: m_stage = wr_data;
        4'd5: m_hi = (m_hi & 64'hFFFFFFFF_00000000) | wr_data;
        4'd6: m_hi = (m_hi & 64'h00000000_FFFFFFFF) | (longint'(wr_data) << 32);
        4'd7: m_lo = (m_lo & 64'hFFFFFFFF_00000000) | wr_data;
        4'd8: m_lo = (m_lo & 64'h00000000_FFFFFFFF) | (longint'(wr_data) << 32);
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R3 model ns", tod_ns, m_ns);
      chk("R3 model sec", tod_sec, m_sec);
      chk("R7 model pps", pps_out, m_lvl);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk); rd_addr = a; #1 v = rd_data;
  endtask

  task automatic rd_clr(output logic [31:0] v);
    @(negedge clk); rd_addr = 4'd13; rd_en = 1; #1 v = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, x, s;
    cycles(4);
    rst_n = 1;
    // R1 reset state
    #1;
    chk("R1 sec", tod_sec, 0);
    chk("R1 ns", tod_ns, 0);
    chk("R1 pps", pps_out, 1);
    rd(4'd13, v); chk("R1 capture flag", v, 0);
    rd(4'd2, v);  chk("R1 inc reset", v, 10);
    rd(4'd0, v);  chk("R1 ctrl reset", v, 0);
    // R4 disabled holds
    cycles(3);
    chk("R4 disabled hold", tod_ns, 0);
    // R2 integer increment
    wr(4'd0, 1);
    cycles(5);
    chk("R2 five steps of 10", tod_ns, 50);
    // R2/R6 fractional carry, new increment from next cycle
    wr(4'd1, 32'h8000_0000);
    x = tod_ns;
    cycles(2);
    chk("R2 R6 two steps of 10.5", tod_ns, x + 21);
    // R3 boundary at 999,999,999
    wr(4'd1, 0); wr(4'd2, 1);
    wr(4'd3, 5); wr(4'd4, 999_999_998);
    chk("R5 loaded ns", tod_ns, 999_999_998);
    chk("R5 loaded sec", tod_sec, 5);
    cycles(1);
    chk("R3 no wrap at 0x3B9AC9FF", tod_ns, 999_999_999);
    chk("R3 sec before wrap", tod_sec, 5);
    cycles(1);
    chk("R3 wrap to 0", tod_ns, 0);
    chk("R3 sec after wrap", tod_sec, 6);
    // R3 excess kept with fraction
    wr(4'd1, 32'h8000_0000); wr(4'd2, 3);
    wr(4'd3, 9); wr(4'd4, 999_999_998);
    cycles(1);
    chk("R3 excess kept", tod_ns, 1);
    chk("R3 sec step", tod_sec, 10);
    cycles(1);
    chk("R3 R5 fraction carried", tod_ns, 5);
    // R4 disable and zero increment
    wr(4'd0, 0);
    x = tod_ns;
    cycles(4);
    chk("R4 enable low holds", tod_ns, x);
    wr(4'd0, 1); wr(4'd2, 0); wr(4'd1, 0);
    x = tod_ns; s = tod_sec;
    cycles(4);
    chk("R4 zero inc holds ns", tod_ns, x);
    chk("R4 zero inc holds sec", tod_sec, s);
    // R7 pulse output
    wr(4'd6, 25); wr(4'd5, 32'h4000_0000); wr(4'd8, 40); wr(4'd7, 0);
    wr(4'd2, 10);
    wr(4'd3, 0); wr(4'd4, 0);
    chk("R7 high after load", pps_out, 1);
    cycles(2);
    chk("R7 still high at 20", pps_out, 1);
    cycles(1);
    chk("R7 low at 30", pps_out, 0);
    cycles(3);
    chk("R7 still low", pps_out, 0);
    cycles(1);
    chk("R7 high with carried excess", pps_out, 1);
    cycles(60);
    // R8 capture
    @(negedge clk); x = tod_ns; s = tod_sec; evt_in = 1;
    @(negedge clk); evt_in = 0;
    rd(4'd12, v); chk("R8 capture ns", v, x);
    rd(4'd11, v); chk("R8 capture sec", v, s);
    rd_clr(v); chk("R8 flag set", v, 1);
    rd(4'd13, v); chk("R8 flag cleared by read", v, 0);
    @(negedge clk); x = tod_ns; evt_in = 1;
    cycles(3);
    evt_in = 0;
    rd(4'd12, v); chk("R8 held level captures once", v, x);
    rd_clr(v);
    @(negedge clk); evt_in = 1; rd_addr = 4'd13; rd_en = 1;
    @(negedge clk); evt_in = 0; rd_en = 0;
    rd(4'd13, v); chk("R8 capture wins over clear", v, 1);
    // R9 read map
    rd(4'd6, v);  chk("R9 hi int", v, 25);
    rd(4'd5, v);  chk("R9 hi frac", v, 32'h4000_0000);
    rd(4'd2, v);  chk("R9 inc int", v, 10);
    rd(4'd0, v);  chk("R9 ctrl", v, 1);
    rd(4'd4, v);  chk("R9 load ns reads 0", v, 0);
    rd(4'd15, v); chk("R9 unmapped", v, 0);
    rd(4'd10, v); chk("R9 live ns", v, tod_ns);
    cycles(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule